// File: doc/BRIEF.md
# 32-Pin GPIO Bank with Per-Pin Interrupt Detection

The block is one bank of general-purpose pins with a small memory-mapped register set. Each pin can be an input or an output. Output pins drive the value held in a data register. Input pins pass through a synchroniser, so software reads a metastability-free copy of the pin level through the same data address.

Every pin can also raise an interrupt. A per-pin trigger mode is built from one bit in each of three parallel type registers. The mode selects rising edge, falling edge, either edge, high level or low level. A detected event latches a status bit, but only while the pin's enable bit is set. Software clears a status bit by writing a 1 to it. A single interrupt line goes high whenever any pin has both its status bit and its enable bit set.

The register bus is a plain single-cycle port. A write is taken on the clock edge on which select and write are both high. A read returns data combinationally while select is high and write is low.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset every register reads 0, pin_oe is all zero, pin_out is all zero and irq is low.
- R2: Register offset 0x00 holds the output data and offset 0x04 holds the direction. A direction bit of 1 drives pin_oe high for that pin, and pin_out follows the data register bit.
- R3: A read of offset 0x00 returns the data register bit for each output pin. For each input pin it returns the pin level after two synchroniser flops.
- R4: The type bit codes (type2,type1,type0) = (0,0,1) select rising edge. A 0-to-1 transition sets the status bit, and a 1-to-0 transition does not.
- R5: The code (0,0,0) selects falling edge. A 1-to-0 transition sets the status bit, and a 0-to-1 transition does not.
- R6: The code (1,0,1) selects both edges. Every transition of the pin sets the status bit.
- R7: The codes (0,1,1) and (0,1,0) select high level and low level. The status bit is set on every cycle the level is active. After a clear, the bit reads 0 for one cycle and is set again on the following cycle while the level persists.
- R8: Writing the status register at 0x18 clears each bit written as 1 and leaves each bit written as 0 unchanged. A clear takes priority over an event arriving in the same cycle.
- R9: An event on a pin whose enable bit is 0 does not set its status bit. Setting the enable later does not recover an edge that has already passed.
- R10: irq is high exactly when some pin has both its status bit and its enable bit set. Clearing the enable masks irq while leaving the status bit readable.
- R11: Enable, type0, type1 and type2 sit at offsets 0x08, 0x0C, 0x10 and 0x14, and each reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally during a read, 0 otherwise |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |
| irq | output | 1 | Summary interrupt |

## Verification
The assertions assume that bus_addr and bus_wdata are stable and known whenever bus_sel is high, and that a write lasts exactly one clock. The bench drives every bus and pin change on the falling edge and holds each access for one full cycle, so every sampled value is settled. The assertions also assume that pin_in changes are far enough apart for the synchroniser to pass each level through. The bench keeps each pin level for at least three clocks before it reads status. It also writes the enable register last, after the type registers and a status clear, so no stale level or edge fires while a mode is being set up.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  // Plain configuration registers, laid out every 4 bytes from offset 0.
  localparam int unsigned CFG_DATA = 0;
  localparam int unsigned CFG_DIR  = 1;
  localparam int unsigned CFG_IEN  = 2;
  localparam int unsigned CFG_TY0  = 3;
  localparam int unsigned CFG_TY1  = 4;
  localparam int unsigned CFG_TY2  = 5;
  localparam int unsigned NUM_CFG  = 6;

  // The status register follows the configuration block.
  localparam int unsigned STS_OFS  = NUM_CFG * 4;

  function automatic int unsigned cfg_offset(input int unsigned idx);
    return idx * 4;
  endfunction

  typedef enum logic [2:0] {
    TM_FALL  = 3'd0,
    TM_RISE  = 3'd1,
    TM_BOTH  = 3'd2,
    TM_LLOW  = 3'd3,
    TM_LHIGH = 3'd4
  } trig_mode_e;

  // The level bit dominates, then the both-edges bit, then the polarity bit.
  function automatic trig_mode_e decode_mode(input logic t2, input logic t1,
                                             input logic t0);
    if (t1)      return t0 ? TM_LHIGH : TM_LLOW;
    else if (t2) return TM_BOTH;
    else if (t0) return TM_RISE;
    else         return TM_FALL;
  endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_nxt;

  always_comb begin
    chain_nxt[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      chain_nxt[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpb_trig.sv
module gpb_trig
  import gpb_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] ty0,
  input  logic [W-1:0] ty1,
  input  logic [W-1:0] ty2,
  output logic [W-1:0] evt
);

  logic [W-1:0] hist_q;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= lvl;
    end
  end

  assign rise = lvl & ~hist_q;
  assign fall = ~lvl & hist_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic hit;
    always_comb begin
      unique case (decode_mode(ty2[i], ty1[i], ty0[i]))
        TM_RISE:  hit = rise[i];
        TM_BOTH:  hit = rise[i] | fall[i];
        TM_LLOW:  hit = ~lvl[i];
        TM_LHIGH: hit = lvl[i];
        default:  hit = fall[i];
      endcase
    end
    assign evt[i] = hit;
  end

endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
  import gpb_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_sync,
  input  logic [W-1:0]      evt,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      ty0_q,
  output logic [W-1:0]      ty1_q,
  output logic [W-1:0]      ty2_q,
  output logic [W-1:0]      sts_q
);

  localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(STS_OFS);

  logic                     wr_go;
  logic                     rd_go;
  logic [NUM_CFG-1:0][W-1:0] cfg_q;

  assign wr_go = bus_sel & bus_wr;
  assign rd_go = bus_sel & ~bus_wr;

  // One plain read/write register per configuration slot.
  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(cfg_offset(i));
    logic         ce;
    logic [W-1:0] nxt;
    logic [W-1:0] val_q;

    always_comb begin
      ce  = wr_go && (bus_addr == MY_ADDR);
      nxt = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (ce) begin
        val_q <= nxt;
      end
    end

    assign cfg_q[i] = val_q;
  end

  assign dout_q = cfg_q[CFG_DATA];
  assign dir_q  = cfg_q[CFG_DIR];
  assign en_q   = cfg_q[CFG_IEN];
  assign ty0_q  = cfg_q[CFG_TY0];
  assign ty1_q  = cfg_q[CFG_TY1];
  assign ty2_q  = cfg_q[CFG_TY2];

  // Latched status: set by enabled events, cleared by writing ones.
  logic [W-1:0] sts_set;
  logic [W-1:0] sts_clr;
  logic [W-1:0] sts_nxt;
  logic         sts_ce;

  always_comb begin
    sts_set = evt & en_q;
    sts_clr = (wr_go && (bus_addr == STS_ADDR)) ? bus_wdata : '0;
    sts_nxt = (sts_q | sts_set) & ~sts_clr;
    sts_ce  = (|sts_set) | (|sts_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sts_ce) begin
      sts_q <= sts_nxt;
    end
  end

  // Read mux. The data slot merges driven and sampled bits by direction.
  logic [W-1:0] data_view;
  assign data_view = (dout_q & dir_q) | (pin_sync & ~dir_q);

  always_comb begin
    bus_rdata = '0;
    if (rd_go) begin
      for (int unsigned i = 0; i < NUM_CFG; i++) begin
        if (bus_addr == ADDR_W'(cfg_offset(i))) begin
          bus_rdata = (i == CFG_DATA) ? data_view : cfg_q[i];
        end
      end
      if (bus_addr == STS_ADDR) begin
        bus_rdata = sts_q;
      end
    end
  end

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int unsigned PINS        = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq
);

  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] evt;
  logic [PINS-1:0] dout_q;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] en_q;
  logic [PINS-1:0] ty0_q;
  logic [PINS-1:0] ty1_q;
  logic [PINS-1:0] ty2_q;
  logic [PINS-1:0] sts_q;

  gpb_sync #(
    .W      (PINS),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  gpb_trig #(
    .W (PINS)
  ) trig_i (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (pin_sync),
    .ty0   (ty0_q),
    .ty1   (ty1_q),
    .ty2   (ty2_q),
    .evt   (evt)
  );

  gpb_regs #(
    .W      (PINS),
    .ADDR_W (ADDR_W)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_sync  (pin_sync),
    .evt       (evt),
    .dout_q    (dout_q),
    .dir_q     (dir_q),
    .en_q      (en_q),
    .ty0_q     (ty0_q),
    .ty1_q     (ty1_q),
    .ty2_q     (ty2_q),
    .sts_q     (sts_q)
  );

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign irq     = |(sts_q & en_q);

endmodule

// File: rtl/gpb_chk.sv
module gpb_chk
  import gpb_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      pin_oe,
  input logic              irq,
  input logic [W-1:0]      sts_q,
  input logic [W-1:0]      en_q
);

  localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(cfg_offset(CFG_DIR));
  localparam logic [ADDR_W-1:0] IEN_A = ADDR_W'(cfg_offset(CFG_IEN));
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFS);

  logic wr_dir;
  logic wr_ien0;
  logic wr_sts;

  assign wr_dir  = bus_sel && bus_wr && (bus_addr == DIR_A);
  assign wr_ien0 = bus_sel && bus_wr && (bus_addr == IEN_A) && (bus_wdata == '0);
  assign wr_sts  = bus_sel && bus_wr && (bus_addr == STS_A);

  // R2
  dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pin_oe == $past(bus_wdata)));

  // R8
  status_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts |=> ((sts_q & $past(bus_wdata)) == '0));

  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q) & ~$past(en_q)) == '0));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien0 |=> !irq);

endmodule

bind gpio_bank_irq gpb_chk #(
  .W      (PINS),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .sts_q     (sts_q),
  .en_q      (en_q)
);

// File: tb/gpio_bank_irq_tb_top.sv
module gpio_bank_irq_tb_top;

  localparam logic [4:0] A_DATA = 5'h00;
  localparam logic [4:0] A_DIR  = 5'h04;
  localparam logic [4:0] A_IEN  = 5'h08;
  localparam logic [4:0] A_TY0  = 5'h0C;
  localparam logic [4:0] A_TY1  = 5'h10;
  localparam logic [4:0] A_TY2  = 5'h14;
  localparam logic [4:0] A_STS  = 5'h18;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int vectors;
  int miscompares;

  gpio_bank_irq dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Disable interrupts, program a mode, clear status, then enable.
  task automatic setup(input logic [31:0] t0, input logic [31:0] t1,
                       input logic [31:0] t2, input logic [31:0] en);
    wr(A_IEN, '0);
    wr(A_TY0, t0);
    wr(A_TY1, t1);
    wr(A_TY2, t2);
    wr(A_STS, '1);
    wr(A_IEN, en);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    logic [31:0] acc;
    acc = '0;
    rd(A_DATA, v); acc |= v;
    rd(A_DIR, v);  acc |= v;
    rd(A_IEN, v);  acc |= v;
    rd(A_TY0, v);  acc |= v;
    rd(A_TY1, v);  acc |= v;
    rd(A_TY2, v);  acc |= v;
    rd(A_STS, v);  acc |= v;
    chk("R1 registers", acc, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_dir_data();
    wr(A_DIR, 32'h0000_FFFF);
    wr(A_DATA, 32'hA5A5_1234);
    chk("R2 pin_oe", pin_oe, 32'h0000_FFFF);
    chk("R2 pin_out", pin_out, 32'hA5A5_1234);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    @(negedge clk);
    pin_in = 32'hC3C3_FFFF;
    settle();
    rd(A_DATA, v);
    chk("R3 merged data", v, 32'hC3C3_1234);
    @(negedge clk);
    pin_in = 32'h0;
    settle();
    rd(A_DATA, v);
    chk("R3 inputs low", v, 32'h0000_1234);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(A_TY0, 32'h1111_0001);
    wr(A_TY1, 32'h2222_0002);
    wr(A_TY2, 32'h4444_0004);
    wr(A_IEN, 32'h8888_0008);
    rd(A_IEN, v); chk("R11 enable", v, 32'h8888_0008);
    rd(A_TY0, v); chk("R11 type0", v, 32'h1111_0001);
    rd(A_TY1, v); chk("R11 type1", v, 32'h2222_0002);
    rd(A_TY2, v); chk("R11 type2", v, 32'h4444_0004);
    setup('0, '0, '0, '0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    setup(32'h0001_0000, '0, '0, 32'h0001_0000);
    @(negedge clk); pin_in[16] = 1'b1;
    settle();
    rd(A_STS, v); chk("R4 rise sets", v, 32'h0001_0000);
    chk("R4 irq", {31'd0, irq}, 32'd1);
    wr(A_STS, 32'h0001_0000);
    @(negedge clk); pin_in[16] = 1'b0;
    settle();
    rd(A_STS, v); chk("R4 fall ignored", v, '0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    setup('0, '0, '0, 32'h0001_0000);
    @(negedge clk); pin_in[16] = 1'b1;
    settle();
    rd(A_STS, v); chk("R5 rise ignored", v, '0);
    @(negedge clk); pin_in[16] = 1'b0;
    settle();
    rd(A_STS, v); chk("R5 fall sets", v, 32'h0001_0000);
  endtask

  task automatic t_both();
    logic [31:0] v;
    setup(32'h0002_0000, '0, 32'h0002_0000, 32'h0002_0000);
    @(negedge clk); pin_in[17] = 1'b1;
    settle();
    rd(A_STS, v); chk("R6 rise sets", v, 32'h0002_0000);
    wr(A_STS, 32'h0002_0000);
    @(negedge clk); pin_in[17] = 1'b0;
    settle();
    rd(A_STS, v); chk("R6 fall sets", v, 32'h0002_0000);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    setup(32'h0003_0000, '0, 32'h0003_0000, 32'h0003_0000);
    @(negedge clk); pin_in[17:16] = 2'b11;
    settle();
    rd(A_STS, v); chk("R8 both latched", v, 32'h0003_0000);
    wr(A_STS, 32'h0000_0000);
    rd(A_STS, v); chk("R8 zero write keeps", v, 32'h0003_0000);
    wr(A_STS, 32'h0001_0000);
    rd(A_STS, v); chk("R8 one bit cleared", v, 32'h0002_0000);
    wr(A_STS, 32'h0002_0000);
    rd(A_STS, v); chk("R8 all cleared", v, '0);
    @(negedge clk); pin_in[17:16] = 2'b00;
    settle();
  endtask

  task automatic t_level();
    logic [31:0] v;
    setup(32'h0010_0000, 32'h0030_0000, '0, '0);
    @(negedge clk); pin_in[21] = 1'b1;
    settle();
    wr(A_IEN, 32'h0030_0000);
    @(negedge clk);
    rd(A_STS, v); chk("R7 high idle", v, '0);
    @(negedge clk); pin_in[20] = 1'b1;
    settle();
    rd(A_STS, v); chk("R7 high sets", v, 32'h0010_0000);
    wr(A_STS, 32'h0010_0000);
    rd(A_STS, v); chk("R7 cleared one cycle", v, '0);
    @(negedge clk);
    rd(A_STS, v); chk("R7 high resets", v, 32'h0010_0000);
    @(negedge clk); pin_in[20] = 1'b0;
    settle();
    wr(A_STS, '1);
    @(negedge clk);
    rd(A_STS, v); chk("R7 high gone", v, '0);
    @(negedge clk); pin_in[21] = 1'b0;
    settle();
    rd(A_STS, v); chk("R7 low sets", v, 32'h0020_0000);
    @(negedge clk); pin_in[21] = 1'b1;
    settle();
    wr(A_STS, '1);
    @(negedge clk);
    rd(A_STS, v); chk("R7 low gone", v, '0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    setup(32'h0040_0000, '0, '0, '0);
    @(negedge clk); pin_in[22] = 1'b1;
    settle();
    rd(A_STS, v); chk("R9 disabled no status", v, '0);
    chk("R9 disabled no irq", {31'd0, irq}, 32'd0);
    wr(A_IEN, 32'h0040_0000);
    repeat (2) @(negedge clk);
    rd(A_STS, v); chk("R9 past edge not recovered", v, '0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    setup(32'h0080_0000, '0, '0, 32'h0080_0000);
    @(negedge clk); pin_in[23] = 1'b1;
    settle();
    chk("R10 irq raised", {31'd0, irq}, 32'd1);
    wr(A_IEN, '0);
    chk("R10 irq masked", {31'd0, irq}, 32'd0);
    rd(A_STS, v); chk("R10 status kept", v, 32'h0080_0000);
    wr(A_IEN, 32'h0080_0000);
    chk("R10 irq unmasked", {31'd0, irq}, 32'd1);
    wr(A_STS, 32'h0080_0000);
    chk("R10 irq after clear", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    vectors = 0;
    miscompares = 0;
    rst_n = 1'b0;
    bus_sel = 1'b0;
    bus_wr = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_data();
    t_readback();
    t_regmap();
    t_rise();
    t_fall();
    t_both();
    t_w1c();
    t_level();
    t_gate();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule